// File: doc/BRIEF.md
# Split-Array Data Address Translation Buffer

This block caches virtual-to-physical translations for three page sizes at once: 4 KB, 2 MB and 1 GB. Each size has its own set-associative array, with its own split of the 48-bit virtual address into tag, set index and page offset. A single lookup probes all three arrays in parallel. One clock later the block returns a hit flag, the size of the page that matched, and the physical address. That address is the cached frame number of the matching entry, with the untranslated low bits of the request appended.

Translations come in through a fill port. The fill carries a page-size code, and the block writes the entry into the array for that size only. A flush input empties every array in one cycle. The block serves a load/store pipeline: the pipeline issues a lookup with a valid/ready pair and reads the response in the next cycle. On a miss, an outside agent fetches the translation and loads it through the fill port.

Top module: `multi_size_tlb`

## Requirements
- R1: `req_ready_o` is always 1. A request presented with `req_valid_i` high produces `rsp_valid_o` high exactly one clock later. A cycle with no request produces `rsp_valid_o` low one clock later.
- R2: Page-size code 2'b00 means 4 KB. The 4 KB array has 16 sets of 4 ways, indexed by VA[15:12] and tagged by VA[47:16]. A hit in it returns size 2'b00 and the physical address {frame, VA[11:0]}.
- R3: Page-size code 2'b01 means 2 MB. The 2 MB array has 8 sets of 4 ways, indexed by VA[23:21] and tagged by VA[47:24]. A hit in it returns size 2'b01 and the physical address {frame, VA[20:0]}.
- R4: Page-size code 2'b10 means 1 GB. The 1 GB array has 4 fully associative entries tagged by VA[47:30]. A hit in it returns size 2'b10 and the physical address {frame, VA[29:0]}.
- R5: A fill with size code 2'b11 writes nothing. Each legal fill is visible only through the array of its own size.
- R6: A fill with a new tag writes the lowest-numbered invalid way of its set. If every way in the set is valid, the fill replaces the way named by that set's round-robin pointer, and the pointer then advances. From reset or flush, this evicts entries in the order they were filled.
- R7: A fill whose tag is already valid in its set rewrites the frame of that way in place. No other entry of the set is evicted.
- R8: Flush invalidates every entry and resets the replacement pointers. A lookup in the same cycle as a flush misses. A fill in the same cycle as a flush is discarded.
- R9: A lookup in the same cycle as a fill sees the array contents from before that fill.
- R10: If more than one array holds a match, the largest page size wins.
- R11: A response that misses reports a physical address of 0 and size 2'b00.
- R12: After reset no entry is valid and `rsp_valid_o` and `rsp_hit_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Lookup request accepted |
| req_vaddr_i | input | VA_W | Virtual address to translate |
| rsp_valid_o | output | 1 | Lookup result valid |
| rsp_hit_o | output | 1 | Translation found |
| rsp_paddr_o | output | PA_W | Translated physical address |
| rsp_size_o | output | 2 | Page size of the hit (00 4 KB, 01 2 MB, 10 1 GB) |
| fill_valid_i | input | 1 | Write one translation |
| fill_size_i | input | 2 | Page size code of the fill |
| fill_vaddr_i | input | VA_W | Virtual address of the fill |
| fill_paddr_i | input | PA_W | Physical address of the fill; the frame is taken above the offset |
| flush_i | input | 1 | Invalidate all entries |

## Verification
The bench goes after set conflicts that need a fifth fill into a full 4 KB set. A broken replacement pointer evicts the wrong translation, so a later lookup hits on a page that should be gone or misses on one that should remain. It refills existing tags: a design that skips the in-place match creates duplicate ways and pushes out a valid neighbour. It also lets a 1 GB page overlap a 4 KB page, where the wrong priority returns the small page's frame. Lookups in the same cycle as a fill or a flush are probed too, where a design that forwards the fill or ignores the flush reports a hit it should not. Size code 11 must write nothing, and offsets must splice at 12, 21 and 30 bits; an error in either shows up as a wrong physical address or as a hit in the wrong array.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    PG_4K   = 2'd0,
    PG_2M   = 2'd1,
    PG_1G   = 2'd2,
    PG_NONE = 2'd3
  } pg_size_e;
endpackage

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int WAYS  = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAYS-1:0]  match_i,
  input  logic [WAY_W-1:0] rr_i,
  output logic [WAY_W-1:0] way_o,
  output logic             evict_o
);
  // priority: matching way, then lowest invalid way, then round-robin
  always_comb begin
    way_o   = rr_i;
    evict_o = 1'b1;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) begin
        way_o   = WAY_W'(w);
        evict_o = 1'b0;
      end
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_i[w]) begin
        way_o   = WAY_W'(w);
        evict_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/tlb_set_array.sv
module tlb_set_array #(
  parameter int VA_W  = 48,
  parameter int PA_W  = 48,
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int OFF_W = 12,
  localparam int IDX_BITS = $clog2(SETS),
  localparam int IDX_W    = (IDX_BITS > 0) ? IDX_BITS : 1,
  localparam int TAG_W    = VA_W - OFF_W - IDX_BITS,
  localparam int PFN_W    = PA_W - OFF_W,
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic [VA_W-1:0] lk_va_i,
  output logic            lk_hit_o,
  output logic [PA_W-1:0] lk_pa_o,
  input  logic            fill_en_i,
  input  logic [VA_W-1:0] fill_va_i,
  input  logic [PA_W-1:0] fill_pa_i
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [PFN_W-1:0] pfn_q   [SETS][WAYS];
  logic [WAY_W-1:0] rr_q    [SETS];

  logic [IDX_W-1:0] lk_idx, fl_idx;
  logic [TAG_W-1:0] lk_tag, fl_tag;
  logic [PFN_W-1:0] fl_pfn;
  logic [WAYS-1:0]  fl_match;
  logic [WAY_W-1:0] vic_way;
  logic             vic_evict;
  logic             unused_bits;

  if (SETS > 1) begin : g_idx
    assign lk_idx = lk_va_i[OFF_W +: IDX_W];
    assign fl_idx = fill_va_i[OFF_W +: IDX_W];
  end else begin : g_noidx
    assign lk_idx = '0;
    assign fl_idx = '0;
  end

  assign lk_tag      = lk_va_i[VA_W-1 -: TAG_W];
  assign fl_tag      = fill_va_i[VA_W-1 -: TAG_W];
  assign fl_pfn      = fill_pa_i[PA_W-1 -: PFN_W];
  assign unused_bits = ^{fill_va_i[OFF_W-1:0], fill_pa_i[OFF_W-1:0]};

  always_comb begin
    lk_hit_o = 1'b0;
    lk_pa_o  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (valid_q[lk_idx][w] && tag_q[lk_idx][w] == lk_tag) begin
        lk_hit_o = 1'b1;
        lk_pa_o  = {pfn_q[lk_idx][w], lk_va_i[OFF_W-1:0]};
      end
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++)
      fl_match[w] = valid_q[fl_idx][w] && (tag_q[fl_idx][w] == fl_tag);
  end

  tlb_victim_sel #(.WAYS(WAYS)) u_victim (
    .valid_i (valid_q[fl_idx]),
    .match_i (fl_match),
    .rr_i    (rr_q[fl_idx]),
    .way_o   (vic_way),
    .evict_o (vic_evict)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else if (flush_i) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else if (fill_en_i) begin
      valid_q[fl_idx][vic_way] <= 1'b1;
      if (vic_evict) rr_q[fl_idx] <= rr_q[fl_idx] + WAY_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i && !flush_i) begin
      tag_q[fl_idx][vic_way] <= fl_tag;
      pfn_q[fl_idx][vic_way] <= fl_pfn;
    end
  end
endmodule

// File: rtl/multi_size_tlb.sv
module multi_size_tlb
  import tlb_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int PA_W    = 48,
  parameter int WAYS    = 4,
  parameter int SETS_4K = 16,
  parameter int SETS_2M = 8,
  localparam int N_SIZES = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [VA_W-1:0] req_vaddr_i,
  output logic            rsp_valid_o,
  output logic            rsp_hit_o,
  output logic [PA_W-1:0] rsp_paddr_o,
  output logic [1:0]      rsp_size_o,
  input  logic            fill_valid_i,
  input  logic [1:0]      fill_size_i,
  input  logic [VA_W-1:0] fill_vaddr_i,
  input  logic [PA_W-1:0] fill_paddr_i,
  input  logic            flush_i
);
  logic [N_SIZES-1:0] hit_vec;
  logic [PA_W-1:0]    pa_vec [N_SIZES];
  logic               sel_hit;
  logic [PA_W-1:0]    sel_pa;
  pg_size_e           sel_size;

  assign req_ready_o = 1'b1;

  for (genvar g = 0; g < N_SIZES; g++) begin : g_size
    localparam int OFF  = (g == 0) ? 12 : ((g == 1) ? 21 : 30);
    localparam int NSET = (g == 0) ? SETS_4K : ((g == 1) ? SETS_2M : 1);
    tlb_set_array #(
      .VA_W (VA_W), .PA_W (PA_W), .SETS (NSET), .WAYS (WAYS), .OFF_W (OFF)
    ) u_arr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .flush_i   (flush_i),
      .lk_va_i   (req_vaddr_i),
      .lk_hit_o  (hit_vec[g]),
      .lk_pa_o   (pa_vec[g]),
      .fill_en_i (fill_valid_i && (fill_size_i == 2'(g))),
      .fill_va_i (fill_vaddr_i),
      .fill_pa_i (fill_paddr_i)
    );
  end

  // largest page wins on overlap
  always_comb begin
    sel_hit  = |hit_vec;
    sel_pa   = '0;
    sel_size = PG_4K;
    if (hit_vec[2]) begin
      sel_pa = pa_vec[2]; sel_size = PG_1G;
    end else if (hit_vec[1]) begin
      sel_pa = pa_vec[1]; sel_size = PG_2M;
    end else if (hit_vec[0]) begin
      sel_pa = pa_vec[0]; sel_size = PG_4K;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_paddr_o <= '0;
      rsp_size_o  <= PG_4K;
    end else begin
      rsp_valid_o <= req_valid_i && req_ready_o;
      if (req_valid_i && req_ready_o && !flush_i && sel_hit) begin
        rsp_hit_o   <= 1'b1;
        rsp_paddr_o <= sel_pa;
        rsp_size_o  <= sel_size;
      end else begin
        rsp_hit_o   <= 1'b0;
        rsp_paddr_o <= '0;
        rsp_size_o  <= PG_4K;
      end
    end
  end
endmodule

// File: rtl/multi_size_tlb_chk.sv
module multi_size_tlb_chk
  import tlb_pkg::*;
#(
  parameter int PA_W = 48
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic [29:0]     vaddr_lo_i,
  input logic            flush_i,
  input logic            rsp_valid_o,
  input logic            rsp_hit_o,
  input logic [PA_W-1:0] rsp_paddr_o,
  input logic [1:0]      rsp_size_o
);
  assert_rsp_follows_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> rsp_valid_o);
  assert_no_spurious_rsp_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  assert_off_4k_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !flush_i) |=> ((rsp_hit_o && rsp_size_o == PG_4K) ->
      rsp_paddr_o[11:0] == $past(vaddr_lo_i[11:0])));
  assert_off_2m_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !flush_i) |=> ((rsp_hit_o && rsp_size_o == PG_2M) ->
      rsp_paddr_o[20:0] == $past(vaddr_lo_i[20:0])));
  assert_off_1g_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !flush_i) |=> ((rsp_hit_o && rsp_size_o == PG_1G) ->
      rsp_paddr_o[29:0] == $past(vaddr_lo_i)));
  assert_size_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> (rsp_size_o != PG_NONE && rsp_valid_o));
  assert_flush_same_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && flush_i) |=> !rsp_hit_o);
  assert_after_flush_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && $past(flush_i)) |=> !rsp_hit_o);
  assert_miss_clean_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_paddr_o == '0 && rsp_size_o == PG_4K));
endmodule

bind multi_size_tlb multi_size_tlb_chk #(.PA_W(PA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .vaddr_lo_i  (req_vaddr_i[29:0]),
  .flush_i     (flush_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_hit_o   (rsp_hit_o),
  .rsp_paddr_o (rsp_paddr_o),
  .rsp_size_o  (rsp_size_o)
);

// File: tb/multi_size_tlb_tb.sv
`timescale 1ns/1ps
module multi_size_tlb_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_vaddr = '0;
  logic        rsp_valid, rsp_hit;
  logic [47:0] rsp_paddr;
  logic [1:0]  rsp_size;
  logic        fill_valid = 1'b0;
  logic [1:0]  fill_size = '0;
  logic [47:0] fill_vaddr = '0, fill_paddr = '0;
  logic        flush = 1'b0;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  multi_size_tlb u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_paddr_o(rsp_paddr), .rsp_size_o(rsp_size),
    .fill_valid_i(fill_valid), .fill_size_i(fill_size), .fill_vaddr_i(fill_vaddr),
    .fill_paddr_i(fill_paddr), .flush_i(flush)
  );

  // reference model: per set list in fill order, oldest first
  logic [47:0] m_tag [3][16][4];
  logic [47:0] m_pfn [3][16][4];
  int          m_cnt [3][16];

  function automatic int f_off(int s);   return (s == 0) ? 12 : ((s == 1) ? 21 : 30); endfunction
  function automatic int f_sets(int s);  return (s == 0) ? 16 : ((s == 1) ? 8 : 1);   endfunction
  function automatic int f_tsh(int s);   return (s == 0) ? 16 : ((s == 1) ? 24 : 30); endfunction
  function automatic int f_idx(int s, logic [47:0] va);
    return int'((va >> f_off(s)) % 48'(f_sets(s)));
  endfunction

  function automatic void m_flush();
    for (int s = 0; s < 3; s++) for (int i = 0; i < 16; i++) m_cnt[s][i] = 0;
  endfunction

  function automatic void m_lookup(input logic [47:0] va, output bit hit,
                                   output logic [47:0] pa, output logic [1:0] sz);
    hit = 0; pa = '0; sz = 2'd0;
    for (int s = 2; s >= 0; s--) begin
      int i = f_idx(s, va);
      logic [47:0] t = va >> f_tsh(s);
      for (int w = 0; w < m_cnt[s][i]; w++) begin
        if (!hit && m_tag[s][i][w] == t) begin
          hit = 1;
          pa  = (m_pfn[s][i][w] << f_off(s)) | (va & ((48'd1 << f_off(s)) - 48'd1));
          sz  = 2'(s);
        end
      end
    end
  endfunction

  function automatic void m_fill(int s, logic [47:0] va, logic [47:0] pa);
    int i = f_idx(s, va);
    logic [47:0] t = va >> f_tsh(s);
    logic [47:0] p = pa >> f_off(s);
    for (int w = 0; w < m_cnt[s][i]; w++) begin
      if (m_tag[s][i][w] == t) begin
        m_pfn[s][i][w] = p;
        return;
      end
    end
    if (m_cnt[s][i] < 4) begin
      m_tag[s][i][m_cnt[s][i]] = t;
      m_pfn[s][i][m_cnt[s][i]] = p;
      m_cnt[s][i]++;
    end else begin
      for (int w = 0; w < 3; w++) begin
        m_tag[s][i][w] = m_tag[s][i][w+1];
        m_pfn[s][i][w] = m_pfn[s][i][w+1];
      end
      m_tag[s][i][3] = t;
      m_pfn[s][i][3] = p;
    end
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(input string req, input bit rq, input logic [47:0] va,
                      input bit fv, input logic [1:0] fs, input logic [47:0] fva,
                      input logic [47:0] fpa, input bit fl);
    bit e_hit; logic [47:0] e_pa; logic [1:0] e_sz;
    req_valid = rq; req_vaddr = va;
    fill_valid = fv; fill_size = fs; fill_vaddr = fva; fill_paddr = fpa;
    flush = fl;
    e_hit = 0; e_pa = '0; e_sz = 2'd0;
    if (rq && !fl) m_lookup(va, e_hit, e_pa, e_sz);
    if (fl) m_flush();
    else if (fv && fs != 2'd3) m_fill(int'(fs), fva, fpa);
    @(negedge clk);
    chk("R1", "ready", 64'(req_ready), 64'd1);
    chk("R1", "rsp_valid", 64'(rsp_valid), 64'(rq));
    if (rq) begin
      chk(req, "hit", 64'(rsp_hit), 64'(e_hit));
      chk(req, "paddr", 64'(rsp_paddr), 64'(e_pa));
      chk(req, "size", 64'(rsp_size), 64'(e_sz));
    end
  endtask

  task automatic lk(input string req, input logic [47:0] va);
    step(req, 1, va, 0, 2'd0, '0, '0, 0);
  endtask
  task automatic fl(input string req, input logic [1:0] s, input logic [47:0] va, input logic [47:0] pa);
    step(req, 0, '0, 1, s, va, pa, 0);
  endtask

  function automatic logic [47:0] rnd_va();
    logic [47:0] v;
    v[47:30] = 18'($urandom % 6);
    v[29:24] = 6'($urandom % 3);
    v[23:21] = 3'($urandom);
    v[20:16] = 5'($urandom % 2);
    v[15:12] = 4'($urandom);
    v[11:0]  = 12'($urandom);
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    m_flush();
    repeat (3) @(negedge clk);
    chk("R12", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "rsp_hit after reset", 64'(rsp_hit), 64'd0);
    lk("R12", 48'h0000_0000_1234);
    lk("R11", 48'h0001_2345_6789);

    // R9: fill and lookup in same cycle, then visible
    step("R9", 1, 48'h0000_0012_3abc, 1, 2'd0, 48'h0000_0012_3000, 48'h0000_aaaa_b000, 0);
    lk("R2", 48'h0000_0012_3f01);
    // R3: 2 MB
    fl("R3", 2'd1, 48'h0000_0340_0000, 48'h0000_7760_0000);
    lk("R3", 48'h0000_035f_fabc);
    lk("R3", 48'h0000_0360_0000);
    // R4: 1 GB, offset bits free
    fl("R4", 2'd2, 48'h0000_8000_0000, 48'h0012_4000_0000);
    lk("R4", 48'h0000_bade_cafe);
    for (int k = 3; k < 7; k++) fl("R4", 2'd2, 48'(k) << 30, 48'(k + 100) << 30);
    lk("R4", 48'h0000_8000_0123);
    lk("R4", 48'h0001_8000_0000);
    // R5: illegal size code writes nothing
    fl("R5", 2'd3, 48'h0000_0055_5000, 48'h0000_0099_9000);
    lk("R5", 48'h0000_0055_5000);
    // R6: five tags into 4K set 3
    for (int k = 1; k <= 5; k++) fl("R6", 2'd0, (48'(k) << 16) | 48'h3000, 48'(k) << 20);
    for (int k = 1; k <= 5; k++) lk("R6", (48'(k) << 16) | 48'h3456);
    // R7: rewrite tag 3 in place, all others remain
    fl("R7", 2'd0, 48'h0000_0003_3000, 48'h0000_0fed_c000);
    for (int k = 1; k <= 5; k++) lk("R7", (48'(k) << 16) | 48'h3001);
    fl("R6", 2'd0, 48'h0000_0006_3000, 48'h0000_0060_0000);
    for (int k = 2; k <= 6; k++) lk("R6", (48'(k) << 16) | 48'h3002);
    // R10: 4K page inside a cached 1G page
    fl("R10", 2'd0, 48'h0001_0000_5000, 48'h0000_1111_1000);
    lk("R10", 48'h0001_0000_5abc);
    // R8: flush with lookup and fill in same cycle
    step("R8", 1, 48'h0000_0012_3abc, 1, 2'd0, 48'h0000_0077_7000, 48'h1000, 1);
    lk("R8", 48'h0000_0012_3abc);
    lk("R8", 48'h0000_0077_7000);
    lk("R8", 48'h0000_8000_0000);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      bit rq = ($urandom % 10) < 7;
      bit fv = ($urandom % 10) < 4;
      bit f  = ($urandom % 100) < 2;
      step("R2", rq, rnd_va(), fv, 2'($urandom), rnd_va(), {16'($urandom), 32'($urandom)}, f);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule